// File: doc/BRIEF.md
# Single-Shot Input Period Meter

This block measures how long one period of a digital input lasts. It counts the rising edges of a separate counting clock between two successive active edges of the measured input. The measured input and the counting clock are asynchronous to the system clock, and both are brought into the system clock domain before use. A one-cycle arm strobe starts a measurement. The block then waits for the opening active edge, counts, and at the closing active edge stores the count in a 16-bit read-back register. It then goes idle and ignores the input until it is armed again.

On each completion the block drives a done pulse of fixed width. If interrupts are enabled, it also raises an interrupt request that stays set until it is acknowledged. An optional debounce filter ignores input pulses that are too short. Using the filter delays the done pulse by a fixed number of system cycles. The input period equals the stored count multiplied by the counting-clock period, with an error of at most one counting-clock period.

Every pin is a plain control or status signal. The block has no streaming data path, so it has no valid/ready handshake. The read-back value stays on `result` until the next completion replaces it.

Top module: `period_meter`

## Requirements
- R1: After reset, `result` is 0 and `ovf`, `done_pulse` and `irq` are all 0.
- R2: Let the measured period be M system cycles and the counting-clock period be P system cycles. The stored `result` is then floor(M/P) or ceil(M/P).
- R3: With `fall_sel` = 0, the period runs from one rising edge of `meas_in` to the next rising edge. With `fall_sel` = 1, it runs from one falling edge to the next falling edge.
- R4: Suppose `meas_in` makes its closing change just after a system-clock rising edge. Counting the next rising edge as the 1st, `done_pulse` goes high after the 4th rising edge when `debounce_en` = 0, and after the 20th rising edge when `debounce_en` = 1.
- R5: With `debounce_en` = 1, a level on `meas_in` that lasts fewer than 17 system cycles is ignored. Such pulses neither open nor close a measurement.
- R6: `done_pulse` stays high for exactly 14 system cycles.
- R7: After a completion the block is idle. Later edges on `meas_in` cause no further completion and leave `result` unchanged until `arm` is pulsed again.
- R8: If the count would pass 0xFFFF, `result` saturates at 0xFFFF and `ovf` reads 1. The next completion without saturation clears `ovf`.
- R9: A completion with `irq_en` = 1 sets `irq`. `irq` stays set until `irq_ack` is high at a clock edge. A completion with `irq_en` = 0 leaves `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle strobe that starts a new measurement |
| meas_in | input | 1 | Measured input, asynchronous |
| cnt_clk_in | input | 1 | Counting clock, asynchronous; its rising edges are counted |
| debounce_en | input | 1 | 1 enables the debounce filter on `meas_in` |
| fall_sel | input | 1 | 0 selects rising edges as active, 1 selects falling edges |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears `irq` |
| result | output | 16 | Read-back count of the last measurement |
| ovf | output | 1 | The last measurement saturated |
| done_pulse | output | 1 | Completion pulse, 14 cycles long |
| irq | output | 1 | Interrupt request |

## Verification
`result`, `ovf` and `irq` are updated on the same clock edge that raises `done_pulse`. That edge is the 4th edge after the closing input change, or the 20th edge with debounce on. The bench changes inputs just after a falling edge and numbers the rising edges that follow. After each rising edge it samples at the next falling edge, and it expects `done_pulse` low through edge 3 (or 19), then high for exactly 14 samples. The bench reads `result` and `ovf` only after the pulse has started. It checks the clearing of `irq` in the sample that follows the single acknowledged edge.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_IDLE = 2'd0,
    PM_WAIT = 2'd1,
    PM_RUN  = 2'd2
  } pm_state_t;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/pm_filter.sv
module pm_filter #(
  parameter int DB_LEN = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic db_en,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(DB_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(DB_LEN - 1);

  logic          lvl, lvl_d;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl   <= 1'b0;
      lvl_d <= 1'b0;
      run   <= '0;
    end else begin
      lvl_d <= lvl;
      if (din == lvl) begin
        run <= '0;
      end else if (!db_en || run == LAST) begin
        lvl <= din;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/pm_core.sv
module pm_core
  import pm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             fall_sel,
  input  logic             m_rise,
  input  logic             m_fall,
  input  logic             c_edge,
  output logic             finish,
  output logic [CNT_W-1:0] result,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  pm_state_t        state;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             sat, sat_nxt, act;

  assign act     = fall_sel ? m_fall : m_rise;
  assign cnt_nxt = (c_edge && cnt != MAXV) ? cnt + 1'b1 : cnt;
  assign sat_nxt = sat | (c_edge && cnt == MAXV);
  assign finish  = (state == PM_RUN) && act && !arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PM_IDLE;
      cnt    <= '0;
      sat    <= 1'b0;
      result <= '0;
      ovf    <= 1'b0;
    end else if (arm) begin
      state <= PM_WAIT;
    end else begin
      case (state)
        PM_WAIT: if (act) begin
          state <= PM_RUN;
          cnt   <= '0;
          sat   <= 1'b0;
        end
        PM_RUN: if (act) begin
          result <= cnt_nxt;
          ovf    <= sat_nxt;
          state  <= PM_IDLE;
        end else begin
          cnt <= cnt_nxt;
          sat <= sat_nxt;
        end
        default: state <= PM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pm_pulse.sv
module pm_pulse #(
  parameter int PULSE_CYC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic finish,
  input  logic irq_en,
  input  logic irq_ack,
  output logic done_pulse,
  output logic irq
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
      irq  <= 1'b0;
    end else begin
      if (finish)         left <= PW'(PULSE_CYC);
      else if (left != 0) left <= left - 1'b1;
      if (finish && irq_en) irq <= 1'b1;
      else if (irq_ack)     irq <= 1'b0;
    end
  end

  assign done_pulse = (left != 0);
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DB_DELAY    = 20,
  parameter int PULSE_CYC   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             meas_in,
  input  logic             cnt_clk_in,
  input  logic             debounce_en,
  input  logic             fall_sel,
  input  logic             irq_en,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] result,
  output logic             ovf,
  output logic             done_pulse,
  output logic             irq
);
  localparam int DB_LEN = DB_DELAY - SYNC_STAGES - 1;

  logic [1:0] synced;
  logic       ck_d, c_edge, m_rise, m_fall, finish;

  pm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cnt_clk_in, meas_in}), .q(synced)
  );

  pm_filter #(.DB_LEN(DB_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .db_en(debounce_en), .din(synced[0]),
    .rise(m_rise), .fall(m_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_d <= 1'b0;
    else        ck_d <= synced[1];
  end
  assign c_edge = synced[1] & ~ck_d;

  pm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .arm(arm), .fall_sel(fall_sel),
    .m_rise(m_rise), .m_fall(m_fall), .c_edge(c_edge),
    .finish(finish), .result(result), .ovf(ovf)
  );

  pm_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .finish(finish), .irq_en(irq_en),
    .irq_ack(irq_ack), .done_pulse(done_pulse), .irq(irq)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int CNT_W     = 16,
  parameter int PULSE_CYC = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_en,
  input logic             irq_ack,
  input logic [CNT_W-1:0] result,
  input logic             ovf,
  input logic             done_pulse,
  input logic             irq
);
  localparam int HW = $clog2(PULSE_CYC + 2);
  logic [HW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_len <= '0;
    else if (done_pulse) hi_len <= hi_len + 1'b1;
    else                 hi_len <= '0;
  end

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_pulse) |-> hi_len == HW'(PULSE_CYC));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done_pulse) |-> $stable(result));

  // R8
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> result == {CNT_W{1'b1}});

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en));
endmodule

bind period_meter pm_checker #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_ack(irq_ack),
  .result(result), .ovf(ovf), .done_pulse(done_pulse), .irq(irq)
);

// File: tb/period_meter_tb_top.sv
module period_meter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, meas_in = 0, cnt_clk_in = 0, debounce_en = 0, fall_sel = 0;
  logic irq_en = 0, irq_ack = 0;
  logic [15:0] result;
  logic ovf, done_pulse, irq;

  int errors = 0, checks = 0;
  bit finished = 0;
  int ck_hi = 1, ck_lo = 1, ck_ph = 0;

  always #4 clk = ~clk;

  period_meter dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .meas_in(meas_in),
    .cnt_clk_in(cnt_clk_in), .debounce_en(debounce_en), .fall_sel(fall_sel),
    .irq_en(irq_en), .irq_ack(irq_ack), .result(result), .ovf(ovf),
    .done_pulse(done_pulse), .irq(irq)
  );

  // free-running counting clock, period ck_hi + ck_lo system cycles
  initial forever begin
    @(negedge clk);
    cnt_clk_in = (ck_ph < ck_hi);
    ck_ph = (ck_ph + 1 >= ck_hi + ck_lo) ? 0 : ck_ph + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lo_cnt(input int m, input int p);
    int v = m / p;
    return (v > 65535) ? 65535 : v;
  endfunction

  function automatic int hi_cnt(input int m, input int p);
    int v = (m + p - 1) / p;
    return (v > 65535) ? 65535 : v;
  endfunction

  task automatic pulse_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  // watch done_pulse after the closing change made at the current negedge
  task automatic watch_done(input bit db);
    int lat = db ? 20 : 4;
    for (int j = 1; j <= lat + 15; j++) begin
      bit exp;
      @(posedge clk); @(negedge clk);
      exp = (j >= lat) && (j < lat + 14);
      if (j <= lat) check(done_pulse == exp, "R4 done latency", done_pulse, exp);
      else          check(done_pulse == exp, "R6 done width", done_pulse, exp);
    end
  endtask

  // one measurement of period m, active edges per pf
  task automatic run_meas(input int m, input bit pf, input bit db, input bit ie);
    int p = ck_hi + ck_lo;
    int lo = lo_cnt(m, p), hi = hi_cnt(m, p);
    @(negedge clk);
    fall_sel = pf; debounce_en = db; irq_en = ie;
    meas_in = pf;
    repeat (30) @(negedge clk);
    pulse_arm();
    repeat (30) @(negedge clk);
    meas_in = ~pf;
    repeat (m / 2) @(negedge clk);
    meas_in = pf;
    repeat (m - m / 2) @(negedge clk);
    meas_in = ~pf;
    watch_done(db);
    check(int'(result) >= lo && int'(result) <= hi, "R2 count", result, lo);
    check(ovf == (m / p > 65535), "R8 ovf", ovf, (m / p > 65535));
  endtask

  // R3: rise-to-rise is 120 cycles, fall-to-fall is 130 cycles
  task automatic polarity_case(input bit pf);
    int p = ck_hi + ck_lo;
    int m = pf ? 130 : 120;
    @(negedge clk);
    fall_sel = pf; debounce_en = 0; irq_en = 0; meas_in = 0;
    repeat (30) @(negedge clk);
    pulse_arm();
    repeat (30) @(negedge clk);
    meas_in = 1; repeat (20) @(negedge clk);
    meas_in = 0; repeat (100) @(negedge clk);
    meas_in = 1; repeat (30) @(negedge clk);
    meas_in = 0; repeat (60) @(negedge clk);
    check(int'(result) >= lo_cnt(m, p) && int'(result) <= hi_cnt(m, p),
          pf ? "R3 falling period" : "R3 rising period", result, lo_cnt(m, p));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(result == 16'd0, "R1 result", result, 0);
    check(ovf == 0 && done_pulse == 0 && irq == 0, "R1 flags",
          {ovf, done_pulse, irq}, 0);

    // directed: no debounce, then debounce, period 4 clock
    ck_hi = 2; ck_lo = 2;
    run_meas(200, 1'b0, 1'b0, 1'b0);
    run_meas(200, 1'b1, 1'b1, 1'b0);

    // R3 polarity with asymmetric waveform
    ck_hi = 1; ck_lo = 1;
    polarity_case(1'b0);
    polarity_case(1'b1);

    // R7: idle after completion, further edges ignored
    begin
      logic [15:0] held;
      bit seen = 0;
      run_meas(90, 1'b0, 1'b0, 1'b0);
      held = result;
      for (int k = 0; k < 6; k++) begin
        meas_in = ~meas_in;
        repeat (40) begin @(negedge clk); if (done_pulse) seen = 1; end
      end
      check(!seen, "R7 no completion while idle", seen, 0);
      check(result == held, "R7 result held", result, held);
    end

    // R5: short pulses with debounce on are ignored
    begin
      bit seen = 0;
      int p;
      ck_hi = 3; ck_lo = 2; p = 5;
      @(negedge clk);
      debounce_en = 1; fall_sel = 0; irq_en = 0; meas_in = 0;
      repeat (30) @(negedge clk);
      pulse_arm();
      repeat (10) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        meas_in = 1; repeat (16) @(negedge clk);
        meas_in = 0; repeat (20) begin @(negedge clk); if (done_pulse) seen = 1; end
      end
      repeat (40) begin @(negedge clk); if (done_pulse) seen = 1; end
      check(!seen, "R5 glitch rejected", seen, 0);
      // real period of 150 cycles must now be measured from its own edges
      meas_in = 1; repeat (75) @(negedge clk);
      meas_in = 0; repeat (75) @(negedge clk);
      meas_in = 1;
      watch_done(1'b1);
      check(int'(result) >= lo_cnt(150, p) && int'(result) <= hi_cnt(150, p),
            "R5 period after glitches", result, lo_cnt(150, p));
    end

    // R9: interrupt set, held, acknowledged
    ck_hi = 1; ck_lo = 2;
    run_meas(120, 1'b0, 1'b0, 1'b1);
    check(irq == 1, "R9 irq set", irq, 1);
    repeat (10) @(negedge clk);
    check(irq == 1, "R9 irq held", irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    check(irq == 0, "R9 irq cleared", irq, 0);
    run_meas(120, 1'b0, 1'b0, 1'b0);
    check(irq == 0, "R9 irq disabled", irq, 0);

    // constrained random measurements, fixed seed
    void'($urandom(32'd4711));
    for (int it = 0; it < 8; it++) begin
      ck_hi = 1 + int'($urandom % 4);
      ck_lo = 1 + int'($urandom % 4);
      ck_ph = 0;
      run_meas(60 + int'($urandom % 400), 1'($urandom % 2), 1'($urandom % 2), 1'b0);
    end

    // R8: saturation, then clear on a normal measurement
    ck_hi = 1; ck_lo = 1;
    run_meas(132000, 1'b0, 1'b0, 1'b0);
    check(result == 16'hFFFF, "R8 saturated value", result, 16'hFFFF);
    run_meas(100, 1'b0, 1'b0, 1'b0);
    check(ovf == 0, "R8 ovf cleared", ovf, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule